// File: doc/BRIEF.md
# Register Window Spill and Fill State Controller

This block holds the bookkeeping state of a windowed register file: how many windows can still be saved into, how many can be restored from, how many are known clean, how many belong to another context, and a small state word that selects trap vectors. It also holds the current window pointer. Each command updates the counters and the pointer, or raises a spill, fill or clean-window trap and leaves the state alone. The trap type is a base value plus an offset that is computed from the state word.

A pipeline issues one command per cycle on a valid strobe with an opcode and a data byte. One cycle later the block answers with either an acknowledge pulse or a trap pulse that carries its trap type. The counters, the state word and the software-visible window pointer are outputs. The visible pointer counts in the opposite direction to the internal one.

Top module: `wsf_window_ctl`

## Requirements
- R1: After synchronous reset, with NWIN windows: save count = NWIN-2, restore count = 0, clean count = NWIN-1, other count = 0, state word = 0, visible pointer = NWIN-1, and trap_valid and ack are low.
- R2: A save (opcode 0) that raises no trap decrements the save count, increments the restore count, advances the visible pointer by one modulo NWIN, and pulses ack in the next cycle. ack and trap_valid are never high together.
- R3: A save when the save count is 0 raises a spill trap, SPILL_BASE plus offset, and changes no state. This case wins over the clean-window condition of R4.
- R4: A save with a nonzero save count and clean count equal to restore count raises a clean-window trap of type CLEAN_BASE and changes no state.
- R5: A restore (opcode 1) with a restore count of 0 raises a fill trap, FILL_BASE plus offset, and changes no state. Otherwise it increments the save count, decrements the restore count, and moves the visible pointer back by one modulo NWIN.
- R6: The spill/fill offset is state[2:0]*4 when the other count is 0. When the other count is nonzero it is 0x20 + state[5:3]*4.
- R7: A flush (opcode 2) acknowledges when the save count equals NWIN-2. Otherwise it raises a spill trap with the R6 offset. In both cases it changes no state.
- R8: A saved command (opcode 3) increments the save count. It then decrements the other count if that count is nonzero, and the restore count if it is zero.
- R9: A restored command (opcode 4) increments the restore count and increments the clean count while that count is below NWIN-1. It then decrements the other count if that count is nonzero, and the save count if it is zero.
- R10: A pointer write (opcode 5) sets the visible pointer to data modulo NWIN.
- R11: Opcode 6 writes the state word from data[5:0]. Opcodes 7, 8, 9 and 10 write the save, restore, clean and other counts from data[CW-1:0]. Each of these writes pulses ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command opcode |
| cmd_data | input | DW | Command data byte |
| trap_valid | output | 1 | Trap raised by the previous command |
| trap_type | output | TTW | Trap type of that trap |
| ack | output | 1 | Previous command completed without a trap |
| cansave | output | CW | Save count |
| canrestore | output | CW | Restore count |
| cleanwin | output | CW | Clean count |
| otherwin | output | CW | Other-context count |
| wstate | output | 6 | Trap-vector state word |
| cwp_vis | output | CW | Software-visible window pointer |

## Verification
A save can meet two trap conditions at once: a zero save count and a clean count equal to the restore count. The bench sets both counts to zero and the clean count equal to the restore count, then issues a save. It expects exactly the spill type with the other-context offset, and it expects every count unchanged. A saved or restored command can also change the other count and the clean count in the same cycle. The bench runs those commands with the clean count at its ceiling and with the other count both zero and nonzero, and compares every counter afterwards.

// File: rtl/wsf_pkg.sv
package wsf_pkg;
  typedef enum logic [3:0] {
    OP_SAVE     = 4'd0,
    OP_RESTORE  = 4'd1,
    OP_FLUSH    = 4'd2,
    OP_SAVED    = 4'd3,
    OP_RESTORED = 4'd4,
    OP_WR_PTR   = 4'd5,
    OP_WR_STATE = 4'd6,
    OP_WR_SAVE  = 4'd7,
    OP_WR_REST  = 4'd8,
    OP_WR_CLEAN = 4'd9,
    OP_WR_OTHER = 4'd10
  } wsf_op_e;

  localparam int STW = 6;
endpackage

// File: rtl/wsf_trap_calc.sv
module wsf_trap_calc #(
  parameter int TTW = 9,
  parameter logic [TTW-1:0] SPILL_BASE = 9'h080,
  parameter logic [TTW-1:0] FILL_BASE  = 9'h0C0,
  parameter logic [TTW-1:0] CLEAN_BASE = 9'h024
) (
  input  logic [wsf_pkg::STW-1:0] state_word,
  input  logic                    other_nz,
  output logic [TTW-1:0]          spill_tt,
  output logic [TTW-1:0]          fill_tt,
  output logic [TTW-1:0]          clean_tt
);
  logic [5:0] offs;

  // Nonzero other count selects the upper field and flags bit 5.
  always_comb begin
    if (other_nz) offs = {1'b1, state_word[5:3], 2'b00};
    else          offs = {1'b0, state_word[2:0], 2'b00};
  end

  assign spill_tt = SPILL_BASE + TTW'(offs);
  assign fill_tt  = FILL_BASE + TTW'(offs);
  assign clean_tt = CLEAN_BASE;
endmodule

// File: rtl/wsf_cwp_map.sv
module wsf_cwp_map #(
  parameter int NWIN = 8,
  parameter int DW   = 8,
  localparam int CW  = $clog2(NWIN)
) (
  input  logic [CW-1:0] cwp_int,
  input  logic [DW-1:0] wr_data,
  output logic [CW-1:0] vis,
  output logic [CW-1:0] wr_int,
  output logic [CW-1:0] int_dn,
  output logic [CW-1:0] int_up
);
  localparam logic [CW-1:0] TOP = CW'(NWIN - 1);
  logic [DW-1:0] wr_mod;

  assign vis    = TOP - cwp_int;
  assign wr_mod = wr_data % DW'(NWIN);
  assign wr_int = TOP - CW'(wr_mod);
  assign int_dn = (cwp_int == '0) ? TOP : cwp_int - 1'b1;
  assign int_up = (cwp_int == TOP) ? '0 : cwp_int + 1'b1;
endmodule

// File: rtl/wsf_core.sv
module wsf_core
  import wsf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int TTW  = 9,
  localparam int CW  = $clog2(NWIN)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [3:0]     cmd_op,
  input  logic [STW-1:0] wdat,
  input  logic [CW-1:0]  ptr_wr,
  input  logic [CW-1:0]  ptr_dn,
  input  logic [CW-1:0]  ptr_up,
  input  logic [TTW-1:0] spill_tt,
  input  logic [TTW-1:0] fill_tt,
  input  logic [TTW-1:0] clean_tt,
  output logic           trap_valid,
  output logic [TTW-1:0] trap_type,
  output logic           ack,
  output logic [CW-1:0]  cs,
  output logic [CW-1:0]  cr,
  output logic [CW-1:0]  cl,
  output logic [CW-1:0]  ow,
  output logic [STW-1:0] ws,
  output logic [CW-1:0]  ptr
);
  localparam logic [CW-1:0] TOP  = CW'(NWIN - 1);
  localparam logic [CW-1:0] FULL = CW'(NWIN - 2);

  function automatic logic [CW-1:0] up1(input logic [CW-1:0] v);
    return (v == TOP) ? '0 : v + 1'b1;
  endfunction

  function automatic logic [CW-1:0] dn1(input logic [CW-1:0] v);
    return (v == '0) ? TOP : v - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_valid <= 1'b0;
      trap_type  <= '0;
      ack        <= 1'b0;
      cs         <= FULL;
      cr         <= '0;
      cl         <= TOP;
      ow         <= '0;
      ws         <= '0;
      ptr        <= '0;
    end else begin
      trap_valid <= 1'b0;
      ack        <= 1'b0;
      if (cmd_valid) begin
        unique case (wsf_op_e'(cmd_op))
          OP_SAVE: begin
            if (cs == '0) begin
              trap_valid <= 1'b1;
              trap_type  <= spill_tt;
            end else if (cl == cr) begin
              trap_valid <= 1'b1;
              trap_type  <= clean_tt;
            end else begin
              ack <= 1'b1;
              cs  <= dn1(cs);
              cr  <= up1(cr);
              ptr <= ptr_dn;
            end
          end
          OP_RESTORE: begin
            if (cr == '0) begin
              trap_valid <= 1'b1;
              trap_type  <= fill_tt;
            end else begin
              ack <= 1'b1;
              cr  <= dn1(cr);
              cs  <= up1(cs);
              ptr <= ptr_up;
            end
          end
          OP_FLUSH: begin
            if (cs != FULL) begin
              trap_valid <= 1'b1;
              trap_type  <= spill_tt;
            end else begin
              ack <= 1'b1;
            end
          end
          OP_SAVED: begin
            ack <= 1'b1;
            cs  <= up1(cs);
            if (ow == '0) cr <= dn1(cr);
            else          ow <= dn1(ow);
          end
          OP_RESTORED: begin
            ack <= 1'b1;
            cr  <= up1(cr);
            if (cl < TOP) cl <= cl + 1'b1;
            if (ow == '0) cs <= dn1(cs);
            else          ow <= dn1(ow);
          end
          OP_WR_PTR: begin
            ack <= 1'b1;
            ptr <= ptr_wr;
          end
          OP_WR_STATE: begin
            ack <= 1'b1;
            ws  <= wdat;
          end
          OP_WR_SAVE: begin
            ack <= 1'b1;
            cs  <= wdat[CW-1:0];
          end
          OP_WR_REST: begin
            ack <= 1'b1;
            cr  <= wdat[CW-1:0];
          end
          OP_WR_CLEAN: begin
            ack <= 1'b1;
            cl  <= wdat[CW-1:0];
          end
          OP_WR_OTHER: begin
            ack <= 1'b1;
            ow  <= wdat[CW-1:0];
          end
          default: begin
            ack <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/wsf_window_ctl.sv
module wsf_window_ctl #(
  parameter int NWIN = 8,
  parameter int DW   = 8,
  parameter int TTW  = 9,
  parameter logic [TTW-1:0] SPILL_BASE = 9'h080,
  parameter logic [TTW-1:0] FILL_BASE  = 9'h0C0,
  parameter logic [TTW-1:0] CLEAN_BASE = 9'h024,
  localparam int CW  = $clog2(NWIN)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cmd_valid,
  input  logic [3:0]     cmd_op,
  input  logic [DW-1:0]  cmd_data,
  output logic           trap_valid,
  output logic [TTW-1:0] trap_type,
  output logic           ack,
  output logic [CW-1:0]  cansave,
  output logic [CW-1:0]  canrestore,
  output logic [CW-1:0]  cleanwin,
  output logic [CW-1:0]  otherwin,
  output logic [5:0]     wstate,
  output logic [CW-1:0]  cwp_vis
);
  logic [TTW-1:0] spill_tt, fill_tt, clean_tt;
  logic [CW-1:0]  ptr, ptr_wr, ptr_dn, ptr_up;

  wsf_trap_calc #(
    .TTW(TTW), .SPILL_BASE(SPILL_BASE), .FILL_BASE(FILL_BASE), .CLEAN_BASE(CLEAN_BASE)
  ) i_trap (
    .state_word(wstate),
    .other_nz  (otherwin != '0),
    .spill_tt  (spill_tt),
    .fill_tt   (fill_tt),
    .clean_tt  (clean_tt)
  );

  wsf_cwp_map #(.NWIN(NWIN), .DW(DW)) i_map (
    .cwp_int(ptr),
    .wr_data(cmd_data),
    .vis    (cwp_vis),
    .wr_int (ptr_wr),
    .int_dn (ptr_dn),
    .int_up (ptr_up)
  );

  wsf_core #(.NWIN(NWIN), .TTW(TTW)) i_core (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .wdat      (cmd_data[5:0]),
    .ptr_wr    (ptr_wr),
    .ptr_dn    (ptr_dn),
    .ptr_up    (ptr_up),
    .spill_tt  (spill_tt),
    .fill_tt   (fill_tt),
    .clean_tt  (clean_tt),
    .trap_valid(trap_valid),
    .trap_type (trap_type),
    .ack       (ack),
    .cs        (cansave),
    .cr        (canrestore),
    .cl        (cleanwin),
    .ow        (otherwin),
    .ws        (wstate),
    .ptr       (ptr)
  );
endmodule

// File: rtl/wsf_checker.sv
module wsf_checker #(
  parameter int NWIN = 8,
  localparam int CW  = $clog2(NWIN)
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [3:0]    cmd_op,
  input logic          trap_valid,
  input logic          ack,
  input logic [CW-1:0] cansave,
  input logic [CW-1:0] canrestore,
  input logic [CW-1:0] cleanwin,
  input logic [CW-1:0] cwp_vis
);
  import wsf_pkg::*;

  a_r2_save_moves: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == OP_SAVE && cansave != '0 && cleanwin != canrestore
    |=> ack && !trap_valid && cansave == $past(cansave) - 1'b1
        && canrestore == $past(canrestore) + 1'b1);

  a_r2_one_answer: assert property (@(posedge clk) disable iff (rst)
    !(trap_valid && ack));

  a_r3_spill_keeps_state: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == OP_SAVE && cansave == '0
    |=> trap_valid && !ack && $stable(cansave) && $stable(canrestore) && $stable(cwp_vis));

  a_r5_fill_keeps_state: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == OP_RESTORE && canrestore == '0
    |=> trap_valid && !ack && $stable(cansave) && $stable(cwp_vis));

  a_r7_flush_ready: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == OP_FLUSH && cansave == CW'(NWIN - 2)
    |=> ack && !trap_valid);

  a_r9_clean_ceiling: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_op == OP_RESTORED && cleanwin == CW'(NWIN - 1)
    |=> cleanwin == CW'(NWIN - 1));
endmodule

bind wsf_window_ctl wsf_checker #(.NWIN(NWIN)) i_wsf_checker (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .trap_valid(trap_valid),
  .ack       (ack),
  .cansave   (cansave),
  .canrestore(canrestore),
  .cleanwin  (cleanwin),
  .cwp_vis   (cwp_vis)
);

// File: tb/test_wsf_window_ctl.sv
module test_wsf_window_ctl;
  localparam int CLK_P = 10;
  localparam int NW = 8;

  typedef struct {
    string      tag;
    logic       tv;
    logic [8:0] tt;
    logic       ak;
    logic [2:0] cs, cr, cl, ow;
    logic [5:0] ws;
    logic [2:0] vis;
  } exp_t;

  logic clk = 1'b0, rst = 1'b1, cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [7:0] cmd_data = '0;
  logic trap_valid, ack;
  logic [8:0] trap_type;
  logic [2:0] cansave, canrestore, cleanwin, otherwin, cwp_vis;
  logic [5:0] wstate;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t q[$];
  logic [2:0] m_cs = 3'd6, m_cr = 3'd0, m_cl = 3'd7, m_ow = 3'd0, m_vis = 3'd7;
  logic [5:0] m_ws = '0;

  always #(CLK_P/2) clk = ~clk;

  wsf_window_ctl i_wsf_window_ctl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .trap_valid(trap_valid), .trap_type(trap_type), .ack(ack),
    .cansave(cansave), .canrestore(canrestore), .cleanwin(cleanwin),
    .otherwin(otherwin), .wstate(wstate), .cwp_vis(cwp_vis)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Driver: model from the requirements, then drive and push expectation.
  task automatic cmd(input logic [3:0] op, input logic [7:0] d, input string tag);
    exp_t e;
    logic [8:0] offs;
    offs = (m_ow != 0) ? (9'h20 + {4'd0, m_ws[5:3], 2'b00}) : {4'd0, m_ws[2:0], 2'b00};
    e.tag = tag; e.tv = 0; e.tt = 'x; e.ak = 0;
    case (op)
      4'd0: if (m_cs == 0) begin e.tv = 1; e.tt = 9'h080 + offs; end
            else if (m_cl == m_cr) begin e.tv = 1; e.tt = 9'h024; end
            else begin e.ak = 1; m_cs--; m_cr++; m_vis = 3'((m_vis + 1) % NW); end
      4'd1: if (m_cr == 0) begin e.tv = 1; e.tt = 9'h0C0 + offs; end
            else begin e.ak = 1; m_cr--; m_cs++; m_vis = 3'((m_vis + NW - 1) % NW); end
      4'd2: if (m_cs != 3'(NW - 2)) begin e.tv = 1; e.tt = 9'h080 + offs; end
            else e.ak = 1;
      4'd3: begin e.ak = 1; m_cs++; if (m_ow == 0) m_cr--; else m_ow--; end
      4'd4: begin e.ak = 1; m_cr++; if (m_cl < 3'(NW - 1)) m_cl++;
                  if (m_ow == 0) m_cs--; else m_ow--; end
      4'd5: begin e.ak = 1; m_vis = 3'(d % NW); end
      4'd6: begin e.ak = 1; m_ws = d[5:0]; end
      4'd7: begin e.ak = 1; m_cs = d[2:0]; end
      4'd8: begin e.ak = 1; m_cr = d[2:0]; end
      4'd9: begin e.ak = 1; m_cl = d[2:0]; end
      default: begin e.ak = 1; m_ow = d[2:0]; end
    endcase
    e.cs = m_cs; e.cr = m_cr; e.cl = m_cl; e.ow = m_ow; e.ws = m_ws; e.vis = m_vis;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(posedge clk);
    q.push_back(e);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Monitor: results appear after the edge that took the command.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " trap_valid"}, 9'(trap_valid), 9'(e.tv));
        if (e.tv) chk({e.tag, " trap_type"}, trap_type, e.tt);
        chk({e.tag, " ack"},        9'(ack),        9'(e.ak));
        chk({e.tag, " cansave"},    9'(cansave),    9'(e.cs));
        chk({e.tag, " canrestore"}, 9'(canrestore), 9'(e.cr));
        chk({e.tag, " cleanwin"},   9'(cleanwin),   9'(e.cl));
        chk({e.tag, " otherwin"},   9'(otherwin),   9'(e.ow));
        chk({e.tag, " wstate"},     9'(wstate),     9'(e.ws));
        chk({e.tag, " cwp_vis"},    9'(cwp_vis),    9'(e.vis));
      end
    end
  end

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cansave", 9'(cansave), 9'd6);
    chk("R1 canrestore", 9'(canrestore), 9'd0);
    chk("R1 cleanwin", 9'(cleanwin), 9'd7);
    chk("R1 otherwin", 9'(otherwin), 9'd0);
    chk("R1 wstate", 9'(wstate), 9'd0);
    chk("R1 cwp_vis", 9'(cwp_vis), 9'd7);
    chk("R1 idle", 9'({trap_valid, ack}), 9'd0);

    cmd(4'd1, 8'h00, "R5 fill on empty");
    cmd(4'd2, 8'h00, "R7 flush ready");
    cmd(4'd0, 8'h00, "R2 save ok");
    cmd(4'd2, 8'h00, "R7 flush spill");
    cmd(4'd6, 8'h2B, "R11 write state");
    cmd(4'd1, 8'h00, "R5 restore ok");
    cmd(4'd7, 8'h00, "R11 write save count");
    cmd(4'd0, 8'h00, "R6 spill normal field");
    cmd(4'd10, 8'h02, "R11 write other count");
    cmd(4'd0, 8'h00, "R6 spill other field");
    cmd(4'd1, 8'h00, "R6 fill other field");
    cmd(4'd3, 8'h00, "R8 saved other");
    cmd(4'd9, 8'h00, "R11 write clean count");
    cmd(4'd0, 8'h00, "R4 clean trap");
    cmd(4'd7, 8'h00, "R11 zero save count");
    cmd(4'd0, 8'h00, "R3 spill wins over clean");
    cmd(4'd7, 8'h03, "R11 write save 3");
    cmd(4'd10, 8'h00, "R11 clear other");
    cmd(4'd4, 8'h00, "R9 restored own");
    cmd(4'd10, 8'h01, "R11 other 1");
    cmd(4'd4, 8'h00, "R9 restored other");
    cmd(4'd3, 8'h00, "R8 saved own");
    cmd(4'd9, 8'h07, "R11 clean top");
    cmd(4'd4, 8'h00, "R9 clean ceiling");
    cmd(4'd5, 8'h03, "R10 pointer write");
    cmd(4'd5, 8'h0D, "R10 pointer modulo");
    cmd(4'd5, 8'h07, "R10 pointer top");
    cmd(4'd0, 8'h00, "R2 save wraps pointer");
    cmd(4'd1, 8'h00, "R5 restore wraps back");
    cmd(4'd8, 8'h05, "R11 write restore count");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule